// File: doc/BRIEF.md
# Ping-Pong Digit-Swap Reorder Buffer

This block sits between two stages of a radix-8 FFT pipeline. It stores whole frames of 64 complex words in two banks that take turns. One bank is filled from the input stream in arrival order while the other bank is drained to the output stream. The drain visits the bank at a stride of 8: output position `k = 8a + b` is taken from stored position `8b + a`. This exchanges the two base-8 digits of the index. The same pass turns 8-inverse order (0, 8, 16, …, 56, 1, 9, …) into natural order, and it also serves as the stride-8 transposition needed between two radix-8 passes.

The input side has no back-pressure. A frame opens with `in_sof` and is stored one word per `in_valid`. When the 64th word is stored, the banks change roles, but only if the previous frame has been fully handed to the output register. Otherwise `ovf` pulses and the new frame is thrown away, so the frame being read is not corrupted.

The output side is valid/ready. A word transfers on a cycle where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, every output holds its value. `out_valid` never depends on `out_ready` within the same cycle. Once a frame is committed, its words leave back to back for as long as `out_ready` stays high.

Top module: `dr_pingpong_buf`

## Requirements
- R1: After reset, `out_valid`, `out_sof` and `ovf` are low and no output word is offered until a full frame has been written.
- R2: A frame opens when `in_valid` and `in_sof` are high together, and that word takes stored position 0. Each later `in_valid` word takes the next position (1 to 63) in arrival order, with idle cycles allowed in between. An `in_valid` word that arrives with no frame open is ignored.
- R3: Output position k (0 to 63) carries input position 8·(k mod 8) + k div 8. This is the word whose 3-bit digits k[5:3] and k[2:0] are exchanged.
- R4: `out_sof` is high exactly on output position 0 of each frame, and only while `out_valid` is high. A rise of `out_valid` always carries `out_sof`.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_sof`, `out_re` and `out_im` hold their values on the next cycle.
- R6: If the reader is idle, output position 0 becomes valid on the second rising edge after the cycle in which input word 63 is presented. With `out_ready` held high and frames arriving back to back, every cycle delivers one word with no gaps and no overflow.
- R7: If word 63 of a frame is stored while the previous frame has not yet handed its last word to the output register, `ovf` is high for exactly one cycle and the new frame is discarded. The frame being read is delivered intact.
- R8: `in_sof` arriving in the middle of an open frame restarts the frame at position 0, and the partial frame is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_sof | input | 1 | Input word is position 0 of a frame |
| in_re | input | DATA_W | Input real part |
| in_im | input | DATA_W | Input imaginary part |
| out_ready | input | 1 | Downstream accepts the offered word |
| out_valid | output | 1 | Output word offered |
| out_sof | output | 1 | Offered word is position 0 of a frame |
| out_re | output | DATA_W | Output real part |
| out_im | output | DATA_W | Output imaginary part |
| ovf | output | 1 | One-cycle pulse: a completed frame was dropped |

## Verification
The assertions assume that the upstream stage never needs to be stalled. They also assume that a frame is only counted as complete after 64 stored words, so the writer can never land in the bank the reader is draining. Every stimulus frame opens with `in_sof`. Overflow is provoked only on purpose, by holding `out_ready` low while a second frame is written. Stray and truncated frames are always followed by a clean frame, so every checked output can be traced to one complete input frame. Throttled reads use a pseudo-random `out_ready` pattern, and only one frame is in flight during that test, so the drain rate never has to match the fill rate.

// File: rtl/dr_pingpong_pkg.sv
package dr_pingpong_pkg;
  typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_e;

  function automatic bank_e other_bank(input bank_e b);
    return (b == BANK_A) ? BANK_B : BANK_A;
  endfunction
endpackage

// File: rtl/dr_pp_bank_store.sv
module dr_pp_bank_store
  import dr_pingpong_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  bank_e             wr_bank,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  bank_e             rd_bank,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] rd_word [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [WORD_W-1:0] ram [DEPTH];
    always_ff @(posedge clk) begin
      if (we && (wr_bank == bank_e'(b))) ram[wr_addr] <= wr_data;
    end
    assign rd_word[b] = ram[rd_addr];
  end

  assign rd_data = rd_word[rd_bank];
endmodule

// File: rtl/dr_pp_wr_seq.sv
module dr_pp_wr_seq
  import dr_pingpong_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              rd_free,
  output logic              we,
  output logic [ADDR_W-1:0] wr_addr,
  output bank_e             wr_bank,
  output logic              commit,
  output logic              ovf
);
  logic              active;
  logic [ADDR_W-1:0] cnt;
  logic              last;

  always_comb begin
    we      = in_valid && (in_sof || active);
    wr_addr = in_sof ? '0 : cnt;
    last    = we && !in_sof && (cnt == '1);
    commit  = last && rd_free;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cnt     <= '0;
      wr_bank <= BANK_A;
      ovf     <= 1'b0;
    end else begin
      ovf <= last && !rd_free;
      if (in_valid) begin
        if (in_sof) begin
          active <= 1'b1;
          cnt    <= ADDR_W'(1);
        end else if (active) begin
          cnt <= cnt + 1'b1;
          if (last) active <= 1'b0;
        end
      end
      if (commit) wr_bank <= other_bank(wr_bank);
    end
  end

  // R7: a dropped frame is reported by a single-cycle pulse
  a_r7_ovf_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> !ovf);
endmodule

// File: rtl/dr_pp_rd_seq.sv
module dr_pp_rd_seq
  import dr_pingpong_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DIG_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                commit,
  input  bank_e               commit_bank,
  input  logic                out_ready,
  input  logic [WORD_W-1:0]   rd_data,
  output logic [2*DIG_W-1:0]  rd_addr,
  output bank_e               rd_bank,
  output logic                rd_free,
  output logic                out_valid,
  output logic                out_sof,
  output logic [WORD_W-1:0]   out_data
);
  localparam int ADDR_W = 2 * DIG_W;

  logic              busy;
  logic [ADDR_W-1:0] cnt;
  logic              load;

  always_comb begin
    load    = busy && (!out_valid || out_ready);
    rd_addr = {cnt[DIG_W-1:0], cnt[ADDR_W-1:DIG_W]};
    rd_free = !busy || (load && (cnt == '1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      rd_bank   <= BANK_A;
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_data  <= '0;
    end else begin
      if (load) begin
        out_valid <= 1'b1;
        out_sof   <= (cnt == '0);
        out_data  <= rd_data;
        cnt       <= cnt + 1'b1;
        if (cnt == '1) busy <= 1'b0;
      end else if (out_ready) begin
        out_valid <= 1'b0;
        out_sof   <= 1'b0;
      end
      if (commit) begin
        busy    <= 1'b1;
        cnt     <= '0;
        rd_bank <= commit_bank;
      end
    end
  end

  // R5: stalled output holds
  a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sof)));
  // R4: frame marker only with valid data
  a_r4_sof_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);
  // R4: a fresh burst always starts at position 0
  a_r4_rise_is_sof: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_sof);
endmodule

// File: rtl/dr_pingpong_buf.sv
module dr_pingpong_buf
  import dr_pingpong_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic [DATA_W-1:0] in_re,
  input  logic [DATA_W-1:0] in_im,
  input  logic              out_ready,
  output logic              out_valid,
  output logic              out_sof,
  output logic [DATA_W-1:0] out_re,
  output logic [DATA_W-1:0] out_im,
  output logic              ovf
);
  localparam int ADDR_W = 2 * DIG_W;
  localparam int WORD_W = 2 * DATA_W;

  logic              we, commit, rd_free;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  bank_e             wr_bank, rd_bank;
  logic [WORD_W-1:0] rd_data, out_data;

  dr_pp_wr_seq #(.ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .rd_free(rd_free), .we(we), .wr_addr(wr_addr), .wr_bank(wr_bank),
    .commit(commit), .ovf(ovf)
  );

  dr_pp_bank_store #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .we(we), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .wr_data({in_re, in_im}), .rd_bank(rd_bank), .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  dr_pp_rd_seq #(.WORD_W(WORD_W), .DIG_W(DIG_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .commit(commit), .commit_bank(wr_bank),
    .out_ready(out_ready), .rd_data(rd_data), .rd_addr(rd_addr),
    .rd_bank(rd_bank), .rd_free(rd_free), .out_valid(out_valid),
    .out_sof(out_sof), .out_data(out_data)
  );

  assign out_re = out_data[WORD_W-1:DATA_W];
  assign out_im = out_data[DATA_W-1:0];

  // R2/R7: the writer never stores into the bank still being drained
  a_r7_no_write_into_read_bank: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_free |-> !(we && (wr_bank == rd_bank)));
  // R7: a bank swap and a dropped frame never coincide
  a_r7_commit_excludes_drop: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !ovf);
endmodule

// File: tb/dr_pingpong_buf_bench.sv
module dr_pingpong_buf_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0;
  logic [DW-1:0] in_re = '0, in_im = '0;
  logic out_ready;
  logic out_valid, out_sof, ovf;
  logic [DW-1:0] out_re, out_im;

  logic rdy_mode = 1'b0, rdy_force = 1'b0;
  logic [7:0] lfsr = 8'h5B;
  int cyc = 0;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  int cap_n = 0, ovf_cycles = 0, hold_err = 0;
  logic [DW-1:0] cap_re [512];
  logic [DW-1:0] cap_im [512];
  logic cap_sof [512];
  int cap_cyc [512];
  logic prev_stall = 1'b0, prev_sof = 1'b0;
  logic [DW-1:0] prev_re = '0, prev_im = '0;
  int last_drv_cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) begin
    #1 lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end
  assign out_ready = rdy_mode ? lfsr[0] : rdy_force;

  dr_pingpong_buf #(.DATA_W(DW), .DIG_W(3)) u_dr_pingpong_buf (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_re(in_re), .in_im(in_im), .out_ready(out_ready),
    .out_valid(out_valid), .out_sof(out_sof), .out_re(out_re),
    .out_im(out_im), .ovf(ovf)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall && !(out_valid && out_re == prev_re && out_im == prev_im
                          && out_sof == prev_sof)) hold_err++;
      if (ovf) ovf_cycles++;
      if (out_valid && out_ready && cap_n < 512) begin
        cap_re[cap_n] = out_re; cap_im[cap_n] = out_im;
        cap_sof[cap_n] = out_sof; cap_cyc[cap_n] = cyc;
        cap_n++;
      end
      prev_stall = out_valid && !out_ready;
      prev_re = out_re; prev_im = out_im; prev_sof = out_sof;
    end
  end

  function automatic logic [DW-1:0] mk_re(input int f, input int j);
    return DW'((f << 8) | j);
  endfunction
  function automatic logic [DW-1:0] mk_im(input int f, input int j);
    return mk_re(f, j) ^ 16'hA5C3;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic send_words(input int f, input int n, input int gap);
    for (int j = 0; j < n; j++) begin
      tick();
      in_valid = 1'b1; in_sof = (j == 0);
      in_re = mk_re(f, j); in_im = mk_im(f, j);
      if (j == 63) last_drv_cyc = cyc;
      for (int g = 0; g < gap; g++) begin
        tick(); in_valid = 1'b0; in_sof = 1'b0;
      end
    end
  endtask

  task automatic idle_in();
    tick(); in_valid = 1'b0; in_sof = 1'b0;
  endtask

  task automatic wait_caps(input int n);
    int t = 0;
    while (cap_n < n && t < 5000) begin @(posedge clk); t++; end
    @(negedge clk);
  endtask

  task automatic check_frame(input int base, input int f, input string req);
    for (int k = 0; k < 64; k++) begin
      int j = (k % 8) * 8 + k / 8;
      check(cap_re[base+k] == mk_re(f, j), req, int'(cap_re[base+k]), int'(mk_re(f, j)));
      check(cap_im[base+k] == mk_im(f, j), req, int'(cap_im[base+k]), int'(mk_im(f, j)));
      check(cap_sof[base+k] == (k == 0), "R4 sof position", int'(cap_sof[base+k]), int'(k == 0));
    end
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) tick();
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(ovf == 1'b0, "R1 ovf after reset", int'(ovf), 0);
    check(out_sof == 1'b0, "R1 out_sof after reset", int'(out_sof), 0);
  endtask

  task automatic t_single_frame_gaps();
    int base = cap_n;
    rdy_force = 1'b1;
    send_words(1, 64, 1);
    idle_in();
    wait_caps(base + 64);
    check(cap_n - base == 64, "R2 word count with idle gaps", cap_n - base, 64);
    check_frame(base, 1, "R3 digit swap (gapped input)");
    check(cap_cyc[base] == last_drv_cyc + 2, "R6 first-word latency",
          cap_cyc[base], last_drv_cyc + 2);
  endtask

  task automatic t_stream();
    int base = cap_n;
    int o0 = ovf_cycles;
    rdy_force = 1'b1;
    send_words(2, 64, 0);
    send_words(3, 64, 0);
    send_words(4, 64, 0);
    idle_in();
    wait_caps(base + 192);
    check_frame(base, 2, "R3 stream frame 2");
    check_frame(base + 64, 3, "R3 stream frame 3");
    check_frame(base + 128, 4, "R3 stream frame 4");
    for (int i = 0; i < 191; i++)
      check(cap_cyc[base+i+1] == cap_cyc[base+i] + 1, "R6 gapless output",
            cap_cyc[base+i+1] - cap_cyc[base+i], 1);
    check(ovf_cycles == o0, "R6 no overflow at full rate", ovf_cycles - o0, 0);
  endtask

  task automatic t_backpressure();
    int base = cap_n;
    int h0 = hold_err;
    rdy_mode = 1'b1;
    send_words(5, 64, 0);
    idle_in();
    wait_caps(base + 64);
    rdy_mode = 1'b0;
    check_frame(base, 5, "R5 data under throttled ready");
    check(hold_err == h0, "R5 outputs held while stalled", hold_err - h0, 0);
  endtask

  task automatic t_overflow();
    int base = cap_n;
    int o0 = ovf_cycles;
    rdy_force = 1'b0;
    tick();
    send_words(6, 64, 0);
    idle_in();
    repeat (4) tick();
    @(negedge clk);
    check(out_valid == 1'b1, "R7 frame A offered while stalled", int'(out_valid), 1);
    check(out_re == mk_re(6, 0), "R7 frame A word 0 held", int'(out_re), int'(mk_re(6, 0)));
    send_words(7, 64, 0);
    idle_in();
    repeat (4) tick();
    check(ovf_cycles - o0 == 1, "R7 overflow pulse is one cycle", ovf_cycles - o0, 1);
    rdy_force = 1'b1;
    wait_caps(base + 64);
    check_frame(base, 6, "R7 frame A intact after overflow");
    repeat (100) tick();
    check(cap_n - base == 64, "R7 dropped frame not emitted", cap_n - base, 64);
  endtask

  task automatic t_restart();
    int base = cap_n;
    rdy_force = 1'b1;
    for (int s = 0; s < 5; s++) begin
      tick(); in_valid = 1'b1; in_sof = 1'b0;
      in_re = 16'hDEAD; in_im = 16'hBEEF;
    end
    idle_in();
    repeat (3) tick();
    check(cap_n == base, "R2 stray words ignored", cap_n - base, 0);
    send_words(8, 20, 0);
    send_words(9, 64, 0);
    idle_in();
    wait_caps(base + 64);
    repeat (80) tick();
    check(cap_n - base == 64, "R8 only one frame after restart", cap_n - base, 64);
    check_frame(base, 9, "R8 restarted frame content");
  endtask

  initial begin
    t_reset();
    t_single_frame_gaps();
    t_stream();
    t_backpressure();
    t_overflow();
    t_restart();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule